// File: doc/BRIEF.md
# Recursive Carry-Select Adder

This block is a purely combinational binary adder of a parameterised width. It takes two operands and a carry input and produces their sum together with a carry output. Internally, an adder of a given width is formed from three adders of half that width. The lower half adds the low operand bits using the true carry input. Two copies of the upper half add the high operand bits in parallel, one with a carry input tied to 0 and one tied to 1. The carry out of the lower half then selects between the two upper results, for both the upper sum bits and the final carry.

The same decomposition is applied again to every half-size adder until the adders are one bit wide. Each one-bit adder is a plain full adder. The selection stages are built from a two-to-1 multiplexer made of two AND gates, one OR gate and one inverter.

The block has no clock and no state. It is placed wherever a wide adder is needed and the operand width is a power of two.

Top module: `rcsa_adder`

## Requirements
- R1: For every input combination, the concatenation {cout, sum} equals a + b + cin evaluated at WIDTH+1 bits.
- R2: WIDTH must be a power of two that is at least 1, and defaults to 32. Any other value stops elaboration with an error.
- R3: The lower WIDTH/2 bits of sum equal the low halves of a and b plus cin, truncated to WIDTH/2 bits. They do not depend on the upper operand bits.
- R4: The upper WIDTH/2 bits of sum equal the upper halves of a and b plus the carry out of the lower-half addition, truncated to WIDTH/2 bits.
- R5: When a XOR b is all ones, cout equals cin and every sum bit equals NOT cin.
- R6: With a = 0, b = 0 and cin = 0, sum is 0 and cout is 0.
- R7: When a is all ones, b is all ones and cin is 1, sum is all ones and cout is 1.
- R8: A WIDTH=4 instance produces the correct {cout, sum} for all 512 combinations of a, b and cin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a    | input  | WIDTH | First operand |
| b    | input  | WIDTH | Second operand |
| cin  | input  | 1     | Carry input |
| sum  | output | WIDTH | Sum bits |
| cout | output | 1     | Carry output |

## Verification
The bench drives the carry-propagation extremes, where a carry must pass through every selection level:

- All ones plus one. A design that swaps the two precomputed upper copies, or that feeds the wrong select into the carry multiplexer, returns a nonzero sum or drops the carry out.
- Zero plus zero.
- All ones plus all ones with a carry input of 1. This exposes a lower half that ignores the real carry input.

Exhaustive checking of a 4-bit instance covers the full-adder base case and both recursion levels above it. Seeded random vectors at 32 bits reach a mix of deep carry chains that no small directed set would cover.

// File: rtl/rcsa_pkg.sv
package rcsa_pkg;

   // True when w is a nonzero power of two
   function automatic bit is_pow2(input int w);
      return (w > 0) && ((w & (w - 1)) == 0);
   endfunction

endpackage

// File: rtl/rcsa_mux2.sv
// Two-to-one selector built from two ANDs, one OR and one inverter per bit
module rcsa_mux2 #(
   parameter int WIDTH = 1
) (
   input  logic [WIDTH-1:0] d0,
   input  logic [WIDTH-1:0] d1,
   input  logic             sel,
   output logic [WIDTH-1:0] y
);
   logic sel_n;
   assign sel_n = ~sel;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic t0, t1;
      assign t0   = d0[i] & sel_n;
      assign t1   = d1[i] & sel;
      assign y[i] = t0 | t1;
   end
endmodule

// File: rtl/rcsa_full_add.sv
// One-bit leaf of the recursion
module rcsa_full_add (
   input  logic x,
   input  logic y,
   input  logic ci,
   output logic s,
   output logic co
);
   logic p;
   assign p  = x ^ y;
   assign s  = p ^ ci;
   assign co = (x & y) | (ci & p);
endmodule

// File: rtl/rcsa_node.sv
// Recursive carry-select stage: splits WIDTH into two halves until one bit remains
module rcsa_node #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic             ci,
   output logic [WIDTH-1:0] s,
   output logic             co
);
   localparam int HALF = WIDTH / 2;

   if (WIDTH == 1) begin : g_leaf
      rcsa_full_add u_fa (
         .x  (x[0]),
         .y  (y[0]),
         .ci (ci),
         .s  (s[0]),
         .co (co)
      );
   end else begin : g_split
      logic            lo_co;
      logic            hi0_co, hi1_co;
      logic [HALF-1:0] hi0_s, hi1_s;

      // Lower half sees the true carry input
      rcsa_node #(.WIDTH(HALF)) u_lo (
         .x  (x[HALF-1:0]),
         .y  (y[HALF-1:0]),
         .ci (ci),
         .s  (s[HALF-1:0]),
         .co (lo_co)
      );

      // Upper half precomputed for both possible incoming carries
      rcsa_node #(.WIDTH(HALF)) u_hi0 (
         .x  (x[WIDTH-1:HALF]),
         .y  (y[WIDTH-1:HALF]),
         .ci (1'b0),
         .s  (hi0_s),
         .co (hi0_co)
      );

      rcsa_node #(.WIDTH(HALF)) u_hi1 (
         .x  (x[WIDTH-1:HALF]),
         .y  (y[WIDTH-1:HALF]),
         .ci (1'b1),
         .s  (hi1_s),
         .co (hi1_co)
      );

      rcsa_mux2 #(.WIDTH(HALF)) u_sel_sum (
         .d0  (hi0_s),
         .d1  (hi1_s),
         .sel (lo_co),
         .y   (s[WIDTH-1:HALF])
      );

      rcsa_mux2 #(.WIDTH(1)) u_sel_co (
         .d0  (hi0_co),
         .d1  (hi1_co),
         .sel (lo_co),
         .y   (co)
      );
   end
endmodule

// File: rtl/rcsa_adder.sv
module rcsa_adder #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);
   import rcsa_pkg::*;

   // R2: elaboration stops on a width that is not a power of two
   if (!is_pow2(WIDTH)) begin : g_bad_width
      $error("rcsa_adder: WIDTH %0d is not a power of two", WIDTH);
   end

   rcsa_node #(.WIDTH(WIDTH)) u_root (
      .x  (a),
      .y  (b),
      .ci (cin),
      .s  (sum),
      .co (cout)
   );
endmodule

// File: rtl/rcsa_adder_chk.sv
module rcsa_adder_chk #(
   parameter int WIDTH = 32
) (
   input logic [WIDTH-1:0] a,
   input logic [WIDTH-1:0] b,
   input logic             cin,
   input logic [WIDTH-1:0] sum,
   input logic             cout
);
   logic [WIDTH:0] full_ref;
   assign full_ref = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

   always_comb begin
      p_total_r1: assert (full_ref == {cout, sum})
         else $error("R1 total mismatch");
      p_propagate_r5: assert (!((a ^ b) == {WIDTH{1'b1}}) || (cout == cin && sum == {WIDTH{~cin}}))
         else $error("R5 propagate mismatch");
      p_zero_r6: assert (!(a == '0 && b == '0 && !cin) || (sum == '0 && !cout))
         else $error("R6 zero mismatch");
   end

   if (WIDTH > 1) begin : g_halves
      localparam int H = WIDTH / 2;
      logic [H:0] lo_ref;
      logic [H:0] hi_ref;
      assign lo_ref = {1'b0, a[H-1:0]} + {1'b0, b[H-1:0]} + {{H{1'b0}}, cin};
      assign hi_ref = {1'b0, a[WIDTH-1:H]} + {1'b0, b[WIDTH-1:H]} + {{H{1'b0}}, lo_ref[H]};

      always_comb begin
         p_low_half_r3: assert (sum[H-1:0] == lo_ref[H-1:0])
            else $error("R3 low half mismatch");
         p_high_select_r4: assert (sum[WIDTH-1:H] == hi_ref[H-1:0] && cout == hi_ref[H])
            else $error("R4 high half mismatch");
      end
   end
endmodule

bind rcsa_adder rcsa_adder_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/rcsa_adder_bench.sv
`timescale 1ns/1ps
module rcsa_adder_bench;
   localparam int W  = 32;
   localparam int WS = 4;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic [W-1:0]  a, b, sum;
   logic          cin, cout;
   logic [WS-1:0] sa, sb, ssum;
   logic          scin, scout;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   rcsa_adder #(.WIDTH(W)) u_rcsa_adder (
      .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));

   rcsa_adder #(.WIDTH(WS)) u_rcsa_adder_w4 (
      .a(sa), .b(sb), .cin(scin), .sum(ssum), .cout(scout));

   function automatic logic [W:0] ref_add(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
      return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
   endfunction

   function automatic logic [WS:0] ref_small(input logic [WS-1:0] x, input logic [WS-1:0] y, input logic c);
      return {1'b0, x} + {1'b0, y} + {{WS{1'b0}}, c};
   endfunction

   // Drive on a rising edge, compare on the following falling edge
   task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic c, input string tag);
      logic [W:0] exp;
      @(posedge clk);
      a = x; b = y; cin = c;
      exp = ref_add(x, y, c);
      @(negedge clk);
      checks++;
      if ({cout, sum} !== exp) begin
         errors++;
         $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h", tag, x, y, c, {cout, sum}, exp);
      end
   endtask

   initial begin
      a = '0; b = '0; cin = 1'b0;
      sa = '0; sb = '0; scin = 1'b0;
      void'($urandom(32'h5eed_1234));

      apply('0, '0, 1'b0, "R6 zero plus zero");
      apply('1, 32'd1, 1'b0, "R1 all ones plus one");
      apply('1, '1, 1'b1, "R7 all ones plus all ones with carry");
      apply(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R5 propagate cin=1");
      apply(32'h0F0F_0F0F, 32'hF0F0_F0F0, 1'b0, "R5 propagate cin=0");
      apply(32'h0000_FFFF, 32'h0000_0001, 1'b0, "R4 carry across halves");
      apply(32'hFFFF_0000, 32'h1234_0000, 1'b1, "R3 low half uses cin");
      apply(32'h8000_0000, 32'h8000_0000, 1'b0, "R1 top bit carry");

      for (int i = 0; i < 2000; i++) begin
         apply($urandom, $urandom, 1'($urandom), "R1 random");
      end

      // R8 exhaustive at four bits
      for (int v = 0; v < 512; v++) begin
         logic [WS:0] exp;
         @(posedge clk);
         sa = v[3:0]; sb = v[7:4]; scin = v[8];
         exp = ref_small(v[3:0], v[7:4], v[8]);
         @(negedge clk);
         checks++;
         if ({scout, ssum} !== exp) begin
            errors++;
            $display("FAIL R8 a=%h b=%h cin=%b actual=%h expected=%h", v[3:0], v[7:4], v[8], {scout, ssum}, exp);
         end
      end

      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (100000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule